// File: doc/BRIEF.md
# Chain Readback Threshold Monitor

This block watches the conversion frames that come back from a chain of battery-monitor devices after the chain raises an alert. A falling edge on the active-low alert input opens a scan of a given number of frames. Each frame is assumed to have passed its CRC check already. For every accepted frame the block reads the channel-address field to decide whether the reading is a cell voltage or an auxiliary input. It then compares the 12-bit sample against the high and low thresholds for that class and may emit one event.

While the scan runs, the block adds every cell-voltage sample to a total. The auxiliary samples are left out of it. After the last frame of the scan, the block pulses a done flag, and the total then holds the sum for the whole scan. A small write port loads the four 8-bit thresholds. The comparison extends each threshold with zeros to the sample width.

Top module: `thrmon_top`

## Requirements
- R1: While no scan is open, a falling edge on `alertN` (high in one cycle, low in the next) opens a scan. Opening a scan clears `sumTotal`, latches `scanLen` as the frame count (1 or more) and resets the frame index to 0.
- R2: A frame whose channel field `frameData[26:23]` is 5 or less is a cell-voltage frame. Values 6 to 15 are auxiliary frames. The sample is `frameData[22:11]`, and all other frame bits are ignored.
- R3: Only cell-voltage samples are added to `sumTotal`. An auxiliary frame leaves it unchanged.
- R4: For a cell frame, a sample at or above the cell high threshold gives a rising event. Otherwise, a sample at or below the cell low threshold gives a falling event. Otherwise there is no event. The high test wins even when both tests hold.
- R5: Auxiliary frames use the same rule against the separate auxiliary high and low thresholds.
- R6: After reset both high thresholds are 0xFF and both low thresholds are 0. A write with `thrWe` high stores `thrData` into the threshold chosen by `thrSel`: 0 = cell high, 1 = cell low, 2 = aux high, 3 = aux low.
- R7: An event appears one cycle after its frame, as a single-cycle `evValid`. `evAux` is 1 for auxiliary and 0 for cell. `evRise` is 1 for rising and 0 for falling.
- R8: `evIndex` carries the position of the frame within its scan, counting from 0.
- R9: `scanDone` pulses for one cycle, one cycle after the frame whose count reaches the latched length. At that cycle `sumTotal` holds the scan's full cell sum, and it keeps that value until the next scan opens.
- R10: A frame that arrives while no scan is open produces no event and leaves `sumTotal` unchanged.
- R11: A falling edge on `alertN` during an open scan is ignored: the index and the total carry on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| alertN | input | 1 | Active-low chain alert; its falling edge opens a scan |
| scanLen | input | 8 | Number of frames in the scan, sampled when the scan opens |
| frameValid | input | 1 | Frame strobe |
| frameData | input | 32 | Validated readback frame |
| thrWe | input | 1 | Threshold write enable |
| thrSel | input | 2 | Threshold select (0 cell high, 1 cell low, 2 aux high, 3 aux low) |
| thrData | input | 8 | Threshold write value |
| evValid | output | 1 | Event pulse |
| evAux | output | 1 | Event class: 1 auxiliary, 0 cell |
| evRise | output | 1 | Event direction: 1 rising, 0 falling |
| evIndex | output | 8 | Frame position of the event in the scan |
| sumTotal | output | 32 | Running and final cell-voltage sum |
| scanDone | output | 1 | One-cycle end-of-scan pulse |

## Verification
The assertions assume three things about the inputs. The scan length is at least 1. The sum never wraps within a scan. No new alert edge and frame can end a scan and open the next in back-to-back cycles, which keeps the done flag a single pulse. The stimulus uses scan lengths from 1 to 12 with 12-bit samples, which keeps the total far below 32 bits. Each new alert is issued only after the previous scan's done pulse. A reference model in the bench tracks the open/closed scan state, so it covers both frames sent outside a scan and alert edges dropped inside one.

// File: rtl/thrmon_pkg.sv
package thrmon_pkg;

  // Frame field positions that the upstream readback format fixes
  localparam int CHAN_LSB  = 23;
  localparam int CHAN_MSB  = 26;
  localparam int DATA_LSB  = 11;
  localparam int DATA_MSB  = 22;
  localparam int DATA_W    = DATA_MSB - DATA_LSB + 1;
  localparam int CHAN_W    = CHAN_MSB - CHAN_LSB + 1;
  localparam int LAST_CELL = 5;

  // Threshold slot numbering used by the write port
  localparam int THR_CELL_HI = 0;
  localparam int THR_CELL_LO = 1;
  localparam int THR_AUX_HI  = 2;
  localparam int THR_AUX_LO  = 3;
  localparam int THR_NUM     = 4;

  typedef struct packed {
    logic start;   // open a scan this cycle
    logic accept;  // frame is inside an open scan
    logic last;    // accepted frame completes the scan
  } ctlStrobes_t;

endpackage

// File: rtl/thrmon_ctrl.sv
module thrmon_ctrl
  import thrmon_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             alertN,
  input  logic [CNT_W-1:0] scanLen,
  input  logic             frameValid,
  output ctlStrobes_t      strobes,
  output logic [CNT_W-1:0] frameIdx
);

  logic             alertPrev;
  logic             busy;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] lenQ;
  logic             alertFall;

  assign alertFall      = alertPrev & ~alertN;
  assign strobes.start  = alertFall & ~busy;
  assign strobes.accept = busy & frameValid;
  assign strobes.last   = strobes.accept & (cnt == lenQ - 1'b1);
  assign frameIdx       = cnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      alertPrev <= 1'b1;
      busy      <= 1'b0;
      cnt       <= '0;
      lenQ      <= '0;
    end else begin
      alertPrev <= alertN;
      if (strobes.start) begin
        busy <= 1'b1;
        cnt  <= '0;
        lenQ <= scanLen;
      end else if (strobes.last) begin
        busy <= 1'b0;
      end else if (strobes.accept) begin
        cnt <= cnt + 1'b1;
      end
    end
  end

endmodule

// File: rtl/thrmon_dp.sv
module thrmon_dp
  import thrmon_pkg::*;
#(
  parameter int FRAME_W = 32,
  parameter int SUM_W   = 32,
  parameter int CNT_W   = 8,
  parameter int THR_W   = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctlStrobes_t        strobes,
  input  logic [CNT_W-1:0]   frameIdx,
  input  logic [FRAME_W-1:0] frameData,
  input  logic               thrWe,
  input  logic [1:0]         thrSel,
  input  logic [THR_W-1:0]   thrData,
  output logic               evValid,
  output logic               evAux,
  output logic               evRise,
  output logic [CNT_W-1:0]   evIndex,
  output logic [SUM_W-1:0]   sumTotal,
  output logic               scanDone
);

  localparam int CMP_W = (THR_W > DATA_W) ? THR_W : DATA_W;

  logic [THR_W-1:0] thrReg [THR_NUM];

  // Threshold registers; high slots reset to all ones, low slots to zero
  for (genvar i = 0; i < THR_NUM; i++) begin : g_thr
    localparam logic [THR_W-1:0] RST_VAL =
      (i == THR_CELL_HI || i == THR_AUX_HI) ? {THR_W{1'b1}} : '0;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                              thrReg[i] <= RST_VAL;
      else if (thrWe && (thrSel == 2'(i)))    thrReg[i] <= thrData;
    end
  end

  logic [CHAN_W-1:0] chan;
  logic [DATA_W-1:0] sample;
  logic              isAux;
  logic [CMP_W-1:0]  sampleX, hiX, loX;
  logic              overHi, underLo;

  assign chan    = frameData[CHAN_MSB:CHAN_LSB];
  assign sample  = frameData[DATA_MSB:DATA_LSB];
  assign isAux   = chan > CHAN_W'(LAST_CELL);
  assign sampleX = CMP_W'(sample);
  assign hiX     = CMP_W'(isAux ? thrReg[THR_AUX_HI] : thrReg[THR_CELL_HI]);
  assign loX     = CMP_W'(isAux ? thrReg[THR_AUX_LO] : thrReg[THR_CELL_LO]);
  assign overHi  = sampleX >= hiX;
  assign underLo = sampleX <= loX;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      evValid  <= 1'b0;
      evAux    <= 1'b0;
      evRise   <= 1'b0;
      evIndex  <= '0;
      sumTotal <= '0;
      scanDone <= 1'b0;
    end else begin
      evValid  <= strobes.accept & (overHi | underLo);
      scanDone <= strobes.last;
      if (strobes.accept) begin
        evAux   <= isAux;
        evRise  <= overHi;
        evIndex <= frameIdx;
      end
      if (strobes.start)
        sumTotal <= '0;
      else if (strobes.accept && !isAux)
        sumTotal <= sumTotal + SUM_W'(sample);
    end
  end

endmodule

// File: rtl/thrmon_top.sv
module thrmon_top
  import thrmon_pkg::*;
#(
  parameter int FRAME_W = 32,
  parameter int SUM_W   = 32,
  parameter int CNT_W   = 8,
  parameter int THR_W   = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               alertN,
  input  logic [CNT_W-1:0]   scanLen,
  input  logic               frameValid,
  input  logic [FRAME_W-1:0] frameData,
  input  logic               thrWe,
  input  logic [1:0]         thrSel,
  input  logic [THR_W-1:0]   thrData,
  output logic               evValid,
  output logic               evAux,
  output logic               evRise,
  output logic [CNT_W-1:0]   evIndex,
  output logic [SUM_W-1:0]   sumTotal,
  output logic               scanDone
);

  ctlStrobes_t      strobes;
  logic [CNT_W-1:0] frameIdx;

  thrmon_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .alertN(alertN), .scanLen(scanLen),
    .frameValid(frameValid), .strobes(strobes), .frameIdx(frameIdx)
  );

  thrmon_dp #(.FRAME_W(FRAME_W), .SUM_W(SUM_W), .CNT_W(CNT_W), .THR_W(THR_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .frameIdx(frameIdx),
    .frameData(frameData), .thrWe(thrWe), .thrSel(thrSel), .thrData(thrData),
    .evValid(evValid), .evAux(evAux), .evRise(evRise), .evIndex(evIndex),
    .sumTotal(sumTotal), .scanDone(scanDone)
  );

endmodule

// File: rtl/thrmon_chk.sv
module thrmon_chk
  import thrmon_pkg::*;
#(
  parameter int FRAME_W = 32,
  parameter int SUM_W   = 32,
  parameter int CNT_W   = 8,
  parameter int THR_W   = 8
) (
  input logic               clk,
  input logic               rstN,
  input logic               alertN,
  input logic [CNT_W-1:0]   scanLen,
  input logic               frameValid,
  input logic [FRAME_W-1:0] frameData,
  input logic               thrWe,
  input logic [1:0]         thrSel,
  input logic [THR_W-1:0]   thrData,
  input logic               evValid,
  input logic               evAux,
  input logic               evRise,
  input logic [CNT_W-1:0]   evIndex,
  input logic [SUM_W-1:0]   sumTotal,
  input logic               scanDone
);

  // R10
  ev_needs_frame_chk: assert property (@(posedge clk) disable iff (!rstN)
    evValid |-> $past(frameValid));

  // R3
  aux_keeps_sum_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(frameValid) && ($past(frameData[CHAN_MSB:CHAN_LSB]) > CHAN_W'(LAST_CELL))
     && $past(alertN)) |-> $stable(sumTotal));

  // R9
  done_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    scanDone |=> !scanDone);

  // R1
  sum_no_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(alertN) |-> (sumTotal >= $past(sumTotal)));

  // R7
  ev_aux_known_chk: assert property (@(posedge clk) disable iff (!rstN)
    evValid |-> !$isunknown({evAux, evRise, evIndex}));

endmodule

bind thrmon_top thrmon_chk #(.FRAME_W(FRAME_W), .SUM_W(SUM_W), .CNT_W(CNT_W), .THR_W(THR_W)) u_chk (.*);

// File: tb/sim_thrmon_top.sv
module sim_thrmon_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        alertN = 1'b1;
  logic [7:0]  scanLen = '0;
  logic        frameValid = 1'b0;
  logic [31:0] frameData = '0;
  logic        thrWe = 1'b0;
  logic [1:0]  thrSel = '0;
  logic [7:0]  thrData = '0;
  logic        evValid, evAux, evRise, scanDone;
  logic [7:0]  evIndex;
  logic [31:0] sumTotal;

  always #2 clk = ~clk;

  thrmon_top u0 (.*);

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 0;

  logic [9:0]  evQ [$];
  logic [31:0] sumQ [$];

  // reference model state
  logic [7:0]  mThr [4] = '{8'hFF, 8'h00, 8'hFF, 8'h00};
  bit          mBusy = 0;
  int          mCnt = 0;
  int          mLen = 0;
  logic [31:0] mSum = 0;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: pops expected items as the design produces them
  always @(negedge clk) begin
    if (rstN && !finished) begin
      if (evValid) begin
        if (evQ.size() == 0) check(0, "R10", {evAux, evRise, evIndex}, 0);
        else begin
          logic [9:0] e;
          e = evQ.pop_front();
          check({evAux, evRise, evIndex} == e, e[9] ? "R5" : "R4", {evAux, evRise, evIndex}, e);
        end
      end
      if (scanDone) begin
        if (sumQ.size() == 0) check(0, "R9", sumTotal, 0);
        else begin
          logic [31:0] s;
          s = sumQ.pop_front();
          check(sumTotal == s, "R9", sumTotal, s);
        end
      end
    end
  end

  // driver tasks: all begin and end at posedge + 1
  task automatic frame(input logic [3:0] ch, input logic [11:0] d);
    bit aux;
    aux = ch > 4'd5;
    if (mBusy) begin
      logic [7:0] hi, lo;
      hi = aux ? mThr[2] : mThr[0];
      lo = aux ? mThr[3] : mThr[1];
      if (d >= {4'h0, hi})      evQ.push_back({aux, 1'b1, 8'(mCnt)});
      else if (d <= {4'h0, lo}) evQ.push_back({aux, 1'b0, 8'(mCnt)});
      if (!aux) mSum += 32'(d);
      mCnt++;
      if (mCnt == mLen) begin
        sumQ.push_back(mSum);
        mBusy = 0;
      end
    end
    frameValid = 1'b1;
    frameData  = {5'h1F, ch, d, 11'h555};
    @(posedge clk); #1;
    frameValid = 1'b0;
    frameData  = 32'hFFFF_FFFF;
  endtask

  task automatic openScan(input int len);
    scanLen = 8'(len);
    alertN  = 1'b0;
    if (!mBusy) begin
      mBusy = 1; mCnt = 0; mLen = len; mSum = 0;
    end
    @(posedge clk); #1;
    alertN = 1'b1;
  endtask

  task automatic setThr(input int sel, input logic [7:0] v);
    thrWe = 1'b1; thrSel = 2'(sel); thrData = v;
    mThr[sel] = v;
    @(posedge clk); #1;
    thrWe = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic finish();
    idle(4);
    check(evQ.size() == 0, "R7", evQ.size(), 0);
    check(sumQ.size() == 0, "R9", sumQ.size(), 0);
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    check(0, "watchdog", 0, 1);
    finish();
  end

  initial begin
    logic [31:0] held;
    idle(3);
    #1 rstN = 1'b1;
    @(negedge clk);
    // R6 reset state of outputs
    check(!evValid && !scanDone && sumTotal == 0, "R6", {evValid, scanDone, sumTotal}, 0);
    @(posedge clk); #1;

    // R10: frames before any scan are ignored
    frame(4'd0, 12'hFFF);
    frame(4'd7, 12'h000);
    @(negedge clk);
    check(sumTotal == 0, "R10", sumTotal, 0);
    @(posedge clk); #1;

    // R6 default thresholds, R2 classes, R3 sum, R8 index
    openScan(4);
    frame(4'd0, 12'h0FF);   // cell rise at 0xFF
    frame(4'd1, 12'h000);   // cell fall at 0
    frame(4'd5, 12'h080);   // no event, cell boundary channel
    frame(4'd6, 12'h300);   // aux rise, aux boundary channel
    idle(3);

    // R10: frames after the scan change nothing
    @(negedge clk); held = sumTotal;
    @(posedge clk); #1;
    frame(4'd2, 12'h7FF);
    frame(4'd3, 12'h100);
    @(negedge clk);
    check(sumTotal == held, "R10", sumTotal, held);
    @(posedge clk); #1;

    // R6 programmed thresholds, R4 and R5 boundaries, R11 mid-scan alert
    setThr(0, 8'hC0); setThr(1, 8'h40); setThr(2, 8'h90); setThr(3, 8'h20);
    openScan(12);
    frame(4'd0, 12'h0C0);   // rise
    frame(4'd1, 12'h040);   // fall
    frame(4'd2, 12'h041);   // none
    frame(4'd3, 12'h0BF);   // none
    openScan(12);           // R11: ignored
    frame(4'd4, 12'h800);   // rise
    frame(4'd8, 12'h090);   // aux rise
    frame(4'd9, 12'h020);   // aux fall
    frame(4'd10, 12'h021);  // aux none
    frame(4'd11, 12'h08F);  // aux none
    idle(1);
    frame(4'd15, 12'h000);  // aux fall
    frame(4'd5, 12'h001);   // cell fall
    frame(4'd12, 12'hFFF);  // aux rise, last frame
    idle(3);

    // R4/R5 priority: low above high, high test wins
    setThr(0, 8'h10); setThr(1, 8'hF0); setThr(2, 8'h10); setThr(3, 8'hF0);
    openScan(3);
    frame(4'd2, 12'h020);   // cell, both hold -> rise
    frame(4'd7, 12'h020);   // aux, both hold -> rise
    frame(4'd3, 12'h00F);   // cell, only low -> fall
    idle(3);

    // R9 single-frame scan, R1 clear of previous total
    openScan(1);
    frame(4'd4, 12'h123);
    idle(3);

    finish();
  end

endmodule